// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight general-purpose registers of 32 bits each. Every access names a register by a 3-bit index and a part of that register by a 2-bit part code. The part can be the whole register, its low half-word, its low byte, or the byte just above the low byte. Two read ports are combinational and each returns the selected part zero-extended to 32 bits. One write port updates the register on the rising clock edge. A write of a part changes only that part and keeps every other bit of the register.

Only the first four registers (accumulator, counter, data, base) have byte-sized parts. The other four registers (stack, frame, source, destination) allow only the whole register or its low half-word. A byte access to one of these four is refused. On a read port, the port returns zero and raises its own fault flag. On the write port, the write is dropped and the write fault flag is raised for that cycle.

Reads are not forwarded from the write port. A read that happens in the same cycle as a write to the same register returns the value from before the write.

Top module: `gpr_file`

## Requirements
- R1: While reset is low, and right after reset is released, every register reads as 0.
- R2: The index encoding is 0 accumulator, 1 counter, 2 data, 3 base, 4 stack, 5 frame, 6 source, 7 destination. Part code 00 (full) writes all 32 bits from write data, and a full read returns all 32 bits.
- R3: Part code 01 (word) on a write loads bits 15:0 from write data bits 15:0 and keeps bits 31:16.
- R4: Part code 10 (low byte) on a write loads bits 7:0 from write data bits 7:0 and keeps bits 31:8.
- R5: Part code 11 (high byte) on a write loads bits 15:8 from write data bits 7:0 and keeps bits 31:16 and 7:0.
- R6: Reads are zero-extended. Part 01 returns register bits 15:0, part 10 returns bits 7:0, and part 11 returns bits 15:8, each placed in the low bits of the read data.
- R7: A write with part 10 or 11 to register 4 to 7 leaves the register unchanged, and wr_bad is 1 in that same cycle.
- R8: A read with part 10 or 11 of register 4 to 7 returns data 0 and raises that port's fault flag in the same cycle. Legal reads keep the flag at 0.
- R9: Parts 00 and 01 are legal on registers 4 to 7, for both reads and writes.
- R10: A read of a register in the cycle it is written returns the old value. The new value is visible from the next cycle.
- R11: The two read ports work independently and may select the same register with different parts.
- R12: wr_bad is 0 whenever wr_en is 0, whatever the write address and part are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | 3 | Write register index |
| wr_part | input | 2 | Write part code |
| wr_data | input | 32 | Write value (byte parts use bits 7:0) |
| wr_bad | output | 1 | Write refused (byte part on register 4 to 7) |
| rd0_addr | input | 3 | Read port 0 register index |
| rd0_part | input | 2 | Read port 0 part code |
| rd0_data | output | 32 | Read port 0 zero-extended data |
| rd0_bad | output | 1 | Read port 0 refused access |
| rd1_addr | input | 3 | Read port 1 register index |
| rd1_part | input | 2 | Read port 1 part code |
| rd1_data | output | 32 | Read port 1 zero-extended data |
| rd1_bad | output | 1 | Read port 1 refused access |

## Verification
Two functions can meet in the same cycle: a write, which is either a partial merge or a refused byte write, and a read of the same register through either port. The bench drives both in one cycle. In that cycle it expects the read to show the model's value from before the edge, and it applies the write to its model only after the edge. A refused write that comes together with reads on both ports must leave the flags and the data consistent, and a full read in the following cycle shows whether any bit leaked into the register.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        PART_FULL = 2'b00,
        PART_WORD = 2'b01,
        PART_LOB  = 2'b10,
        PART_HIB  = 2'b11
    } part_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    function automatic logic is_byte_part(input part_e p);
        return (p == PART_LOB) || (p == PART_HIB);
    endfunction

endpackage

// File: rtl/gpr_access_guard.sv
module gpr_access_guard
    import gpr_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int BYTE_REGS = 4,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    part,
    output logic          ok
);
    part_e part_s;

    always_comb begin
        part_s = part_e'(part);
        ok     = !(is_byte_part(part_s) && (int'(addr) >= BYTE_REGS));
    end
endmodule

// File: rtl/gpr_read_lane.sv
module gpr_read_lane
    import gpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    input  logic [1:0]        part,
    input  logic              allow,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        if (allow) begin
            unique case (part_e'(part))
                PART_FULL: data = word;
                PART_WORD: data = {{(DATA_W-WORD_W){1'b0}}, word[WORD_W-1:0]};
                PART_LOB:  data = {{(DATA_W-BYTE_W){1'b0}}, word[BYTE_W-1:0]};
                PART_HIB:  data = {{(DATA_W-BYTE_W){1'b0}}, word[WORD_W-1:BYTE_W]};
                default:   data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    input  logic [1:0]        part,
    output logic [DATA_W-1:0] merged
);
    always_comb begin
        merged = old_val;
        unique case (part_e'(part))
            PART_FULL: merged = new_val;
            PART_WORD: merged = {old_val[DATA_W-1:WORD_W], new_val[WORD_W-1:0]};
            PART_LOB:  merged = {old_val[DATA_W-1:BYTE_W], new_val[BYTE_W-1:0]};
            PART_HIB:  merged = {old_val[DATA_W-1:WORD_W], new_val[BYTE_W-1:0],
                                 old_val[BYTE_W-1:0]};
            default:   merged = old_val;
        endcase
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int BYTE_REGS = 4,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [1:0]        wr_part,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_bad,
    input  logic [AW-1:0]     rd0_addr,
    input  logic [1:0]        rd0_part,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_bad,
    input  logic [AW-1:0]     rd1_addr,
    input  logic [1:0]        rd1_part,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_bad
);
    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

    // write path
    logic              wr_ok;
    logic [DATA_W-1:0] wr_merged;

    gpr_access_guard #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wguard (
        .addr (wr_addr),
        .part (wr_part),
        .ok   (wr_ok)
    );

    gpr_write_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val (mem_q[wr_addr]),
        .new_val (wr_data),
        .part    (wr_part),
        .merged  (wr_merged)
    );

    always_comb wr_bad = wr_en && !wr_ok;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[r] <= '0;
            end else if (wr_en && wr_ok && (wr_addr == AW'(r))) begin
                mem_q[r] <= wr_merged;
            end
        end
    end

    // read ports
    logic [NUM_RD-1:0][AW-1:0]     rd_addr;
    logic [NUM_RD-1:0][1:0]        rd_part;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
    logic [NUM_RD-1:0]             rd_ok;

    always_comb begin
        rd_addr = {rd1_addr, rd0_addr};
        rd_part = {rd1_part, rd0_part};
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_access_guard #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_rguard (
            .addr (rd_addr[p]),
            .part (rd_part[p]),
            .ok   (rd_ok[p])
        );

        gpr_read_lane #(.DATA_W(DATA_W)) u_lane (
            .word  (mem_q[rd_addr[p]]),
            .part  (rd_part[p]),
            .allow (rd_ok[p]),
            .data  (rd_data[p])
        );
    end

    always_comb begin
        rd0_data = rd_data[0];
        rd1_data = rd_data[1];
        rd0_bad  = !rd_ok[0];
        rd1_bad  = !rd_ok[1];
    end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [AW-1:0]                   wr_addr,
    input logic [1:0]                      wr_part,
    input logic                            wr_bad,
    input logic [1:0]                      rd0_part,
    input logic [DATA_W-1:0]               rd0_data,
    input logic                            rd0_bad,
    input logic [DATA_W-1:0]               rd1_data,
    input logic                            rd1_bad,
    input logic [NUM_REGS-1:0][DATA_W-1:0] mem
);
    logic [AW-1:0]     wa_q;
    logic [DATA_W-1:0] wsel_old;
    logic [DATA_W-1:0] wsel_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wa_q <= '0;
        else        wa_q <= wr_addr;
    end

    always_comb begin
        wsel_old = mem[wr_addr];
        wsel_new = mem[wa_q];
    end

    // R7
    wr_refused_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> $stable(mem));

    // R12
    wr_bad_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |-> wr_en);

    // R8
    rd0_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_bad |-> (rd0_data == '0));

    // R8
    rd1_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_bad |-> (rd1_data == '0));

    // R6
    rd0_byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_part[1] |-> (rd0_data[DATA_W-1:8] == '0));

    // R3
    word_keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bad && wr_part == 2'b01)
        |=> (wsel_new[DATA_W-1:16] == $past(wsel_old[DATA_W-1:16])));

    // R4
    lob_keep_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bad && wr_part == 2'b10)
        |=> (wsel_new[DATA_W-1:8] == $past(wsel_old[DATA_W-1:8])));

    // R5
    hib_keep_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bad && wr_part == 2'b11)
        |=> ((wsel_new[DATA_W-1:16] == $past(wsel_old[DATA_W-1:16]))
             && (wsel_new[7:0] == $past(wsel_old[7:0]))));
endmodule

bind gpr_file gpr_file_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_part  (wr_part),
    .wr_bad   (wr_bad),
    .rd0_part (rd0_part),
    .rd0_data (rd0_data),
    .rd0_bad  (rd0_bad),
    .rd1_data (rd1_data),
    .rd1_bad  (rd1_bad),
    .mem      (mem_q)
);

// File: tb/test_gpr_file.sv
`timescale 1ns/100ps
module test_gpr_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [1:0]  wr_part = '0;
    logic [31:0] wr_data = '0;
    logic        wr_bad;
    logic [2:0]  rd0_addr = '0;
    logic [1:0]  rd0_part = '0;
    logic [31:0] rd0_data;
    logic        rd0_bad;
    logic [2:0]  rd1_addr = '0;
    logic [1:0]  rd1_part = '0;
    logic [31:0] rd1_data;
    logic        rd1_bad;

    always #2.5 clk = ~clk;

    gpr_file i_gpr_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_part(wr_part), .wr_data(wr_data),
        .wr_bad(wr_bad),
        .rd0_addr(rd0_addr), .rd0_part(rd0_part), .rd0_data(rd0_data), .rd0_bad(rd0_bad),
        .rd1_addr(rd1_addr), .rd1_part(rd1_part), .rd1_data(rd1_data), .rd1_bad(rd1_bad)
    );

    typedef struct {
        int          kind;
        logic [31:0] d;
        logic        b;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model[8];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    event        chk_ev;

    function automatic logic legal(input logic [2:0] a, input logic [1:0] p);
        return !(p[1] && (a >= 3'd4));
    endfunction

    function automatic logic [31:0] rd_model(input logic [2:0] a, input logic [1:0] p);
        logic [31:0] v;
        v = model[a];
        if (!legal(a, p)) return 32'h0;
        case (p)
            2'b00:   return v;
            2'b01:   return {16'h0, v[15:0]};
            2'b10:   return {24'h0, v[7:0]};
            default: return {24'h0, v[15:8]};
        endcase
    endfunction

    function automatic logic [31:0] wr_model(input logic [31:0] o, input logic [31:0] n,
                                             input logic [1:0] p);
        case (p)
            2'b00:   return n;
            2'b01:   return {o[31:16], n[15:0]};
            2'b10:   return {o[31:8], n[7:0]};
            default: return {o[31:16], n[7:0], o[7:0]};
        endcase
    endfunction

    // driver: applies one cycle of stimulus and queues expected results
    task automatic step(input logic we, input logic [2:0] wa, input logic [1:0] wp,
                        input logic [31:0] wd, input logic [2:0] a0, input logic [1:0] p0,
                        input logic [2:0] a1, input logic [1:0] p1, input string req);
        exp_t e;
        wr_en = we; wr_addr = wa; wr_part = wp; wr_data = wd;
        rd0_addr = a0; rd0_part = p0; rd1_addr = a1; rd1_part = p1;
        e.req = req;
        e.kind = 0; e.d = rd_model(a0, p0); e.b = !legal(a0, p0); sb.push_back(e);
        e.kind = 1; e.d = rd_model(a1, p1); e.b = !legal(a1, p1); sb.push_back(e);
        e.kind = 2; e.d = 32'h0; e.b = we && !legal(wa, wp);      sb.push_back(e);
        #1;
        -> chk_ev;
        @(posedge clk);
        if (we && legal(wa, wp) && rst_n) model[wa] = wr_model(model[wa], wd, wp);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                exp_t        e;
                logic [31:0] gd;
                logic        gb;
                e = sb.pop_front();
                case (e.kind)
                    0:       begin gd = rd0_data; gb = rd0_bad; end
                    1:       begin gd = rd1_data; gb = rd1_bad; end
                    default: begin gd = 32'h0;    gb = wr_bad;  end
                endcase
                total++;
                if (gd !== e.d || gb !== e.b) begin
                    bad++;
                    $display("FAIL %s port%0d: got data=%h flag=%b, expected data=%h flag=%b",
                             e.req, e.kind, gd, gb, e.d, e.b);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        @(negedge clk);
        // R1: reads during reset
        step(1'b1, 3'd0, 2'b00, 32'hFFFF_FFFF, 3'd0, 2'b00, 3'd7, 2'b00, "R1");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd3, 2'b00, 3'd4, 2'b01, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i += 2)
            step(1'b0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i + 1), 2'b00, "R1");

        // R2: full writes to every register, then full reads
        for (int i = 0; i < 8; i++)
            step(1'b1, 3'(i), 2'b00, 32'h1357_9BDF ^ (32'h0101_0101 * (i + 1)),
                 3'd0, 2'b00, 3'd0, 2'b00, "R2");
        for (int i = 0; i < 8; i += 2)
            step(1'b0, 3'd0, 2'b00, 32'h0, 3'(i), 2'b00, 3'(i + 1), 2'b00, "R2");

        // R3: word write keeps upper half
        step(1'b1, 3'd3, 2'b01, 32'hFFFF_BEEF, 3'd3, 2'b00, 3'd3, 2'b01, "R3");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd3, 2'b00, 3'd3, 2'b01, "R3");

        // R4: low byte write
        step(1'b1, 3'd0, 2'b10, 32'hAAAA_AA5C, 3'd1, 2'b00, 3'd2, 2'b00, "R4");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b10, "R4");

        // R5: high byte write takes write data bits 7:0
        step(1'b1, 3'd0, 2'b11, 32'h5555_55C3, 3'd0, 2'b11, 3'd0, 2'b10, "R5");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b00, 3'd0, 2'b11, "R5");

        // R6: zero-extended part reads on several registers
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd1, 2'b01, 3'd1, 2'b10, "R6");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd2, 2'b11, 3'd3, 2'b10, "R6");

        // R7: byte write to register 5 refused while both ports read it
        step(1'b1, 3'd5, 2'b10, 32'h0000_0077, 3'd5, 2'b00, 3'd5, 2'b01, "R7");
        step(1'b1, 3'd7, 2'b11, 32'h0000_0088, 3'd5, 2'b00, 3'd7, 2'b00, "R7");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd7, 2'b00, 3'd5, 2'b00, "R7");

        // R8: byte reads on registers 4..7
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd6, 2'b10, 3'd4, 2'b11, "R8");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd7, 2'b11, 3'd2, 2'b10, "R8");

        // R9: word and full access on registers 4..7
        step(1'b1, 3'd4, 2'b01, 32'h1234_CAFE, 3'd7, 2'b01, 3'd6, 2'b00, "R9");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd4, 2'b00, 3'd4, 2'b01, "R9");

        // R10: read in write cycle sees old value, next cycle new
        step(1'b1, 3'd1, 2'b00, 32'hDEAD_0001, 3'd1, 2'b00, 3'd1, 2'b01, "R10");
        step(1'b1, 3'd1, 2'b11, 32'h0000_00F0, 3'd1, 2'b00, 3'd1, 2'b11, "R10");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd1, 2'b00, 3'd1, 2'b11, "R10");

        // R11: both ports on one register with different parts
        step(1'b0, 3'd2, 2'b00, 32'h0, 3'd2, 2'b11, 3'd2, 2'b01, "R11");
        step(1'b0, 3'd0, 2'b00, 32'h0, 3'd0, 2'b10, 3'd0, 2'b00, "R11");

        // R12: refused-looking write with wr_en low raises no flag, changes nothing
        step(1'b0, 3'd6, 2'b10, 32'hFFFF_FFFF, 3'd6, 2'b00, 3'd0, 2'b00, "R12");
        step(1'b0, 3'd0, 2'b10, 32'hFFFF_FFFF, 3'd6, 2'b00, 3'd0, 2'b00, "R12");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule